// File: doc/BRIEF.md
# Bus Cycle Decoder and Handshake

This block sits between two possible bus masters (a processor and a host communication controller) and four internal slave ports: the DRAM memory controller, the DMA controller, the image engine interface and the modem interface. One master owns the bus at a time, and an input select chooses it. When the selected master pulses its address strobe, the block decodes the 32-bit address into a cycle class: local DRAM, slow I/O or external device. For an internal cycle it raises exactly one request strobe toward the matching slave port. It holds that request until the slave answers ready, and it routes that ready back to the master that started the cycle.

Addresses that fall in no internal window belong to external devices. For these the request engine issues no internal request. The block only forwards the external ready input to the owning master, so that the master can end its cycle. The block does no arbitration. The select input alone decides which master's strobe and address are used.

Top module: `bus_cycle_hub`

## Requirements
- R1: An accepted address in the range 0x8000_0000 to 0x87FF_FFFF starts a DRAM cycle and raises `mem_req`.
- R2: An accepted address in 0x1000_0000..0x7FFF_FFFF or in 0x8800_0000..0xEFFF_FFFF starts a slow I/O cycle. Address bits [25:24] pick the slave: 00 raises `dma_req`, 01 raises `img_req`, and 10 or 11 raises `mdm_req`.
- R3: An accepted address in 0x0000_0000..0x0FFF_FFFF or 0xF000_0000..0xFFFF_FFFF starts an external device cycle, and no internal request is raised.
- R4: During an external cycle, the owning master's ready equals `ext_rdy`. The cycle ends on the clock edge where `ext_rdy` is high.
- R5: An internal request rises on the clock edge that samples the strobe and stays high until the selected slave's ready is sampled high. At that edge the block returns to idle and the request falls.
- R6: At most one of the four request outputs is high at any time.
- R7: An address strobe that arrives while a cycle (internal or external) is in progress is ignored.
- R8: `master_sel` (0 = processor, 1 = host controller) chooses whose strobe and address are accepted. The other master's strobe is ignored, and ready to the non-owning master stays low.
- R9: Master ready is low while idle. During an internal cycle, readies from non-selected slaves and `ext_rdy` have no effect.
- R10: While reset is asserted, and right after it, all requests and both master readies are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_sel | input | 1 | Current bus master: 0 processor, 1 host controller |
| cpu_as | input | 1 | Processor address strobe (one-cycle pulse) |
| cpu_addr | input | 32 | Processor cycle address |
| hcc_as | input | 1 | Host controller address strobe |
| hcc_addr | input | 32 | Host controller cycle address |
| ext_rdy | input | 1 | Ready from an external device |
| mem_rdy | input | 1 | Ready from the memory controller |
| dma_rdy | input | 1 | Ready from the DMA controller |
| img_rdy | input | 1 | Ready from the image engine interface |
| mdm_rdy | input | 1 | Ready from the modem interface |
| mem_req | output | 1 | Request to the memory controller |
| dma_req | output | 1 | Request to the DMA controller |
| img_req | output | 1 | Request to the image engine interface |
| mdm_req | output | 1 | Request to the modem interface |
| cpu_rdy | output | 1 | Cycle-end ready to the processor |
| hcc_rdy | output | 1 | Cycle-end ready to the host controller |

## Verification
The bench walks every window edge, for example 0x7FFF_FFFF against 0x8000_0000, 0x87FF_FFFF against 0x8800_0000, and 0xEFFF_FFFF against 0xF000_0000. An off-by-one comparison there would send a cycle to the wrong slave or to the external path. It also strobes in the middle of a cycle, strobes from the non-selected master, and raises ready on the wrong slave and on the external input during an internal cycle. A design that got any of these wrong would start a second request, answer a master that does not own the bus, or end a cycle before its own slave has finished. Requests held over several wait cycles expose a request that drops too early or lingers after completion.

// File: rtl/bus_cycle_pkg.sv
package bus_cycle_pkg;

    localparam int NUM_SLV = 4;

    // Cycle target. The first four values index the request vector.
    typedef enum logic [2:0] {
        TGT_MEM = 3'd0,
        TGT_DMA = 3'd1,
        TGT_IMG = 3'd2,
        TGT_MDM = 3'd3,
        TGT_EXT = 3'd4
    } tgt_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_INT  = 2'd1,
        ST_PASS = 2'd2
    } cyc_state_e;

    typedef struct packed {
        cyc_state_e         state;
        tgt_e               tgt;
        logic               owner;
        logic [NUM_SLV-1:0] req;
    } cyc_regs_t;

endpackage

// File: rtl/bcd_addr_decode.sv
module bcd_addr_decode
    import bus_cycle_pkg::*;
#(
    parameter int          ADDR_W  = 32,
    parameter logic [31:0] DRAM_LO = 32'h8000_0000,
    parameter logic [31:0] DRAM_HI = 32'h87FF_FFFF,
    parameter logic [31:0] IOA_LO  = 32'h1000_0000,
    parameter logic [31:0] IOA_HI  = 32'h7FFF_FFFF,
    parameter logic [31:0] IOB_LO  = 32'h8800_0000,
    parameter logic [31:0] IOB_HI  = 32'hEFFF_FFFF,
    parameter int          SUB_LSB = 24
) (
    input  logic [ADDR_W-1:0] addr,
    output tgt_e              tgt
);
    localparam int SUB_W = 2;

    logic             in_dram;
    logic             in_io;
    logic [SUB_W-1:0] sub_sel;

    always_comb begin
        in_dram = (addr >= DRAM_LO[ADDR_W-1:0]) && (addr <= DRAM_HI[ADDR_W-1:0]);
        in_io   = ((addr >= IOA_LO[ADDR_W-1:0]) && (addr <= IOA_HI[ADDR_W-1:0])) ||
                  ((addr >= IOB_LO[ADDR_W-1:0]) && (addr <= IOB_HI[ADDR_W-1:0]));
        sub_sel = addr[SUB_LSB +: SUB_W];
        if (in_dram) begin
            tgt = TGT_MEM;
        end else if (in_io) begin
            case (sub_sel)
                2'b00:   tgt = TGT_DMA;
                2'b01:   tgt = TGT_IMG;
                default: tgt = TGT_MDM;
            endcase
        end else begin
            tgt = TGT_EXT;
        end
    end
endmodule

// File: rtl/bcd_ready_route.sv
module bcd_ready_route
    import bus_cycle_pkg::*;
(
    input  cyc_state_e         state,
    input  tgt_e               tgt,
    input  logic               owner,
    input  logic [NUM_SLV-1:0] slv_rdy,
    input  logic               ext_rdy,
    output logic               done,
    output logic               cpu_rdy,
    output logic               hcc_rdy
);
    logic sel_rdy;

    always_comb begin
        sel_rdy = slv_rdy[tgt[1:0]];
        case (state)
            ST_INT:  done = sel_rdy;
            ST_PASS: done = ext_rdy;
            default: done = 1'b0;
        endcase
        cpu_rdy = done & ~owner;
        hcc_rdy = done & owner;
    end
endmodule

// File: rtl/bcd_cycle_ctrl.sv
module bcd_cycle_ctrl
    import bus_cycle_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               start_owner,
    input  tgt_e               tgt_in,
    input  logic               done,
    output cyc_state_e         state,
    output tgt_e               tgt,
    output logic               owner,
    output logic [NUM_SLV-1:0] req
);
    cyc_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.owner = start_owner;
                    r_d.tgt   = tgt_in;
                    r_d.state = (tgt_in == TGT_EXT) ? ST_PASS : ST_INT;
                end
            end
            ST_INT, ST_PASS: begin
                if (done) r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
        r_d.req = '0;
        if (r_d.state == ST_INT) r_d.req[r_d.tgt[1:0]] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.tgt   <= TGT_MEM;
            r_q.owner <= 1'b0;
            r_q.req   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state = r_q.state;
    assign tgt   = r_q.tgt;
    assign owner = r_q.owner;
    assign req   = r_q.req;

    // R6: never more than one request
    a_r6_one_req: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req));
    // R5: a request is held until the slave answers
    a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0 && !done) |=> $stable(req));
    // R5: completion drops the request on the next edge
    a_r5_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INT && done) |=> (req == '0 && state == ST_IDLE));
    // R7: owner and target are frozen while a cycle runs
    a_r7_busy_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !done) |=> ($stable(owner) && $stable(tgt)));
    // R3: external cycles raise no internal request
    a_r3_pass_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PASS) |-> (req == '0));
endmodule

// File: rtl/bus_cycle_hub.sv
module bus_cycle_hub
    import bus_cycle_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_sel,
    input  logic              cpu_as,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              hcc_as,
    input  logic [ADDR_W-1:0] hcc_addr,
    input  logic              ext_rdy,
    input  logic              mem_rdy,
    input  logic              dma_rdy,
    input  logic              img_rdy,
    input  logic              mdm_rdy,
    output logic              mem_req,
    output logic              dma_req,
    output logic              img_req,
    output logic              mdm_req,
    output logic              cpu_rdy,
    output logic              hcc_rdy
);
    logic              start;
    logic [ADDR_W-1:0] sel_addr;
    tgt_e              dec_tgt;
    cyc_state_e        state;
    tgt_e              cur_tgt;
    logic              owner;
    logic [NUM_SLV-1:0] req;
    logic [NUM_SLV-1:0] slv_rdy;
    logic              done;

    always_comb begin
        start    = master_sel ? hcc_as : cpu_as;
        sel_addr = master_sel ? hcc_addr : cpu_addr;
        slv_rdy  = {mdm_rdy, img_rdy, dma_rdy, mem_rdy};
    end

    bcd_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (sel_addr),
        .tgt  (dec_tgt)
    );

    bcd_cycle_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_owner (master_sel),
        .tgt_in      (dec_tgt),
        .done        (done),
        .state       (state),
        .tgt         (cur_tgt),
        .owner       (owner),
        .req         (req)
    );

    bcd_ready_route u_rdy (
        .state   (state),
        .tgt     (cur_tgt),
        .owner   (owner),
        .slv_rdy (slv_rdy),
        .ext_rdy (ext_rdy),
        .done    (done),
        .cpu_rdy (cpu_rdy),
        .hcc_rdy (hcc_rdy)
    );

    assign mem_req = req[TGT_MEM];
    assign dma_req = req[TGT_DMA];
    assign img_req = req[TGT_IMG];
    assign mdm_req = req[TGT_MDM];

    // R8: only one master is answered
    a_r8_one_master: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_rdy && hcc_rdy));
    // R9: with no cycle running nobody gets ready
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !(cpu_rdy || hcc_rdy));
    // R10: requests are low in the first cycle after reset
    a_r10_reset_clear: assert property (@(posedge clk)
        !rst_n |=> ({mem_req, dma_req, img_req, mdm_req} == 4'b0));
endmodule

// File: tb/bus_cycle_hub_tb_top.sv
module bus_cycle_hub_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 16;

    // code: 0 mem, 1 dma, 2 img, 3 modem, 4 external
    localparam logic [31:0] VADDR [NV] = '{
        32'h8000_0000, 32'h87FF_FFFF, 32'h8400_1234, 32'h1000_0000,
        32'h1100_0000, 32'h1200_0000, 32'h7FFF_FFFF, 32'h8800_0000,
        32'h8900_0040, 32'hEFFF_FFFF, 32'hF000_0000, 32'h0FFF_FFFF,
        32'h0000_0000, 32'hFFFF_FFFC, 32'h4300_0000, 32'h8000_0010};
    localparam logic VMAS [NV] = '{
        1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0,
        1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
    localparam logic [2:0] VCODE [NV] = '{
        3'd0, 3'd0, 3'd0, 3'd1, 3'd2, 3'd3, 3'd3, 3'd1,
        3'd2, 3'd3, 3'd4, 3'd4, 3'd4, 3'd4, 3'd3, 3'd0};

    logic clk = 0, rst_n = 0, master_sel = 0;
    logic cpu_as = 0, hcc_as = 0;
    logic [31:0] cpu_addr = '0, hcc_addr = '0;
    logic ext_rdy = 0, mem_rdy = 0, dma_rdy = 0, img_rdy = 0, mdm_rdy = 0;
    logic mem_req, dma_req, img_req, mdm_req, cpu_rdy, hcc_rdy;
    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_cycle_hub dut_i (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] reqs();
        return {mdm_req, img_req, dma_req, mem_req};
    endfunction

    task automatic set_slv(logic [2:0] code, logic v);
        case (code)
            3'd0: mem_rdy = v;
            3'd1: dma_rdy = v;
            3'd2: img_rdy = v;
            3'd3: mdm_rdy = v;
            default: ext_rdy = v;
        endcase
    endtask

    task automatic strobe(logic m, logic [31:0] a);
        @(negedge clk);
        master_sel = m;
        if (m) begin hcc_as = 1; hcc_addr = a; end
        else   begin cpu_as = 1; cpu_addr = a; end
        @(negedge clk);
        cpu_as = 0; hcc_as = 0;
    endtask

    // full cycle with 'waits' cycles of slave wait state
    task automatic run_cycle(string tag, logic m, logic [31:0] a, logic [2:0] code, int waits);
        logic [3:0] er;
        er = (code < 3'd4) ? (4'b1 << code) : 4'b0;
        strobe(m, a);
        chk({tag, " req"}, 32'(reqs()), 32'(er));
        chk({tag, " rdy low before slave"}, 32'({cpu_rdy, hcc_rdy}), 0);
        for (int w = 0; w < waits; w++) begin
            @(negedge clk);
            chk({tag, " R5 req held"}, 32'(reqs()), 32'(er));
        end
        set_slv(code, 1);
        #1;
        chk({tag, " owner rdy"}, 32'({cpu_rdy, hcc_rdy}), m ? 32'd1 : 32'd2);
        @(negedge clk);
        set_slv(code, 0);
        chk({tag, " R5 back to idle"}, 32'(reqs()), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R10 reset state
        repeat (3) @(negedge clk);
        cpu_as = 1; cpu_addr = 32'h8000_0000;
        @(negedge clk);
        chk("R10 reqs in reset", 32'(reqs()), 0);
        chk("R10 rdy in reset", 32'({cpu_rdy, hcc_rdy}), 0);
        cpu_as = 0; rst_n = 1;
        @(negedge clk);
        chk("R10 reqs after reset", 32'(reqs()), 0);

        // table walk: R1 R2 R3 R4 R8
        for (int i = 0; i < NV; i++) begin
            run_cycle($sformatf("R1/R2/R3/R4 vec%0d", i), VMAS[i], VADDR[i], VCODE[i], i % 3);
        end

        // R7: strobe during an internal cycle is ignored
        strobe(0, 32'h8000_0100);
        cpu_as = 1; cpu_addr = 32'h1100_0000;
        @(negedge clk); cpu_as = 0;
        chk("R7 busy strobe ignored", 32'(reqs()), 32'h1);
        mem_rdy = 1; @(negedge clk); mem_rdy = 0;
        @(negedge clk);
        chk("R7 no follow-on request", 32'(reqs()), 0);

        // R7: strobe during an external cycle is ignored
        strobe(1, 32'hF100_0000);
        hcc_as = 1; hcc_addr = 32'h8000_0000;
        @(negedge clk); hcc_as = 0;
        chk("R7 strobe in ext cycle", 32'(reqs()), 0);
        ext_rdy = 1; #1;
        chk("R4 ext rdy to host", 32'({cpu_rdy, hcc_rdy}), 32'd1);
        @(negedge clk); ext_rdy = 0;
        @(negedge clk);
        chk("R7 nothing started", 32'(reqs()), 0);

        // R8: non-selected master strobe ignored
        @(negedge clk);
        master_sel = 0; hcc_as = 1; hcc_addr = 32'h8000_0000;
        @(negedge clk); hcc_as = 0;
        chk("R8 other master ignored", 32'(reqs()), 0);

        // R9: wrong slave ready and ext_rdy ignored in internal cycle
        strobe(0, 32'h1000_0000);
        mem_rdy = 1; img_rdy = 1; mdm_rdy = 1; ext_rdy = 1; #1;
        chk("R9 foreign ready ignored", 32'({cpu_rdy, hcc_rdy}), 0);
        @(negedge clk);
        chk("R9 dma req still held", 32'(reqs()), 32'h2);
        mem_rdy = 0; img_rdy = 0; mdm_rdy = 0; ext_rdy = 0;
        dma_rdy = 1; @(negedge clk); dma_rdy = 0;

        // R9: ready low while idle even if slaves answer
        mem_rdy = 1; ext_rdy = 1; #1;
        chk("R9 idle rdy low", 32'({cpu_rdy, hcc_rdy}), 0);
        mem_rdy = 0; ext_rdy = 0;

        // R8: master_sel change mid-cycle keeps owner
        strobe(1, 32'h8000_0000);
        master_sel = 0; mem_rdy = 1; #1;
        chk("R8 owner kept", 32'({cpu_rdy, hcc_rdy}), 32'd1);
        @(negedge clk); mem_rdy = 0;

        // R6: request vector stays one-hot across a back-to-back run
        run_cycle("R6 b2b a", 0, 32'h1200_0000, 3'd3, 0);
        run_cycle("R6 b2b b", 1, 32'h8800_0000, 3'd1, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule